// File: doc/BRIEF.md
# Dual-Rail Power-Up Sequencer

This block decides when the two buck regulator channels of a power controller are switched on: a low-voltage channel (nominally 3.3 V) and a high-voltage channel (nominally 5 V). It also decides when the reference and internal bias regulator are on, and which rails the power-good supervisor has to watch. All of its inputs are synchronous digital levels. This includes the comparator that reports the external timing capacitor has charged above the reference. The analog charging, the reference and the regulators themselves are outside the block.

A two-bit mode input picks one of two behaviours. In the first, the channels are controlled independently: one run input per channel. In the second, the channels start in sequence: a rising edge on the primary run input starts a leading channel, and the trailing channel follows once the capacitor comparator trips. Which rail leads depends on the sequenced mode chosen. Every output is registered, so it appears one clock after the inputs that cause it are sampled.

Top module: `pwrseq_top`

## Requirements
- R1: While `shdn_n` is low, all enables are low and `op_state` is 00 (shutdown) one cycle later, whatever the other inputs are.
- R2: With `shdn_n` high and neither channel enabled, `bias_en` is 1, both channel enables are 0 and `op_state` is 01 (standby).
- R3: With `seq_mode` 10 or 11 (independent), `en_lo` follows `run_pri` and `en_hi` follows `run_sec` one cycle later; `cap_above` has no effect.
- R4: With `seq_mode` 00 (high rail leads), a rising edge on `run_pri` turns `en_hi` on one cycle later. `en_lo` turns on one cycle after the first sampled cycle in which `en_hi`'s lead state is set and `cap_above` is 1.
- R5: With `seq_mode` 01 (low rail leads), the same rules apply with the roles swapped: `en_lo` leads and `en_hi` trails.
- R6: In a sequenced mode (00 or 01), a low `run_pri` turns both channels off. A `run_pri` that is already high, with no fresh rising edge seen while `shdn_n` is high, starts nothing. `run_sec` has no effect.
- R7: `pg_both` is 1 one cycle after a sequenced mode (00/01) is sampled, meaning the supervisor must watch both rails. It is 0 after an independent mode, meaning only the low rail is watched.
- R8: `op_state` is 10 (run) whenever either channel enable is on.
- R9: Once the trailing channel is on, it stays on when `cap_above` falls. Both channels go off when `run_pri` falls or `shdn_n` goes low, and they need a new `run_pri` rising edge to restart.
- R10: While `rst` is high, all outputs are 0 on the next clock.
- R11: A change of `seq_mode` between the two sequenced codes clears both sequence latches; a new `run_pri` rising edge is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shdn_n | input | 1 | Shutdown, active low |
| run_pri | input | 1 | Primary run input (low-rail enable or sequence start) |
| run_sec | input | 1 | Secondary run input (high-rail enable in independent mode) |
| seq_mode | input | 2 | 00 high leads, 01 low leads, 10/11 independent |
| cap_above | input | 1 | Timing-capacitor comparator, 1 = above reference |
| bias_en | output | 1 | Reference and bias regulator enable |
| en_lo | output | 1 | Low-voltage (3.3 V) channel enable |
| en_hi | output | 1 | High-voltage (5 V) channel enable |
| pg_both | output | 1 | 1 = supervisor watches both rails |
| op_state | output | 2 | 00 shutdown, 01 standby, 10 run |

## Verification
Independent mode is driven with each run input alone, with both together, and with the comparator toggling. This separates a correct per-channel mapping from swapped or cross-coupled enables. Each sequenced mode is driven in two ways: with the comparator rising after the lead has started, and with the comparator already high at the start edge. The second case tells apart a design that lets the trailing rail start in the same cycle as the leader. The tests also cover a primary run held high across shutdown release, comparator drops after the trail has started, run and shutdown removals, and a switch between sequenced codes. Together these show whether the start is edge-triggered, whether the trail is sticky, and whether the latches are cleared.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  localparam int MODE_W  = 2;
  localparam int STATE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    SEQ_HI_LEADS = 2'b00,
    SEQ_LO_LEADS = 2'b01,
    SEQ_INDEP    = 2'b10,
    SEQ_INDEP_X  = 2'b11
  } seq_mode_e;

  typedef enum logic [STATE_W-1:0] {
    ST_SHUTDOWN = 2'b00,
    ST_STANDBY  = 2'b01,
    ST_RUN      = 2'b10
  } op_state_e;

  function automatic logic mode_sequenced(input logic [MODE_W-1:0] m);
    return ~m[MODE_W-1];
  endfunction

  function automatic logic mode_hi_leads(input logic [MODE_W-1:0] m);
    return (m == SEQ_HI_LEADS);
  endfunction
endpackage

// File: rtl/pwrseq_edge.sv
module pwrseq_edge #(
  parameter logic INIT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= INIT;
    else     prev_q <= din;
  end

  assign rise = din & ~prev_q;
endmodule

// File: rtl/pwrseq_chain.sv
module pwrseq_chain (
  input  logic clk,
  input  logic rst,
  input  logic allow,
  input  logic start_rise,
  input  logic hold,
  input  logic mode_same,
  input  logic cap_above,
  output logic lead_d,
  output logic trail_d
);
  logic lead_q, trail_q;
  logic lead_keep, trail_keep, trail_go;

  assign lead_keep  = lead_q & mode_same;
  assign trail_keep = trail_q & mode_same;
  assign trail_go   = lead_keep & cap_above;

  always_comb begin
    lead_d  = allow & hold & (lead_keep | start_rise);
    trail_d = lead_d & (trail_keep | trail_go);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= lead_d;
      trail_q <= trail_d;
    end
  end
endmodule

// File: rtl/pwrseq_outreg.sv
module pwrseq_outreg
  import pwrseq_pkg::*;
#(
  parameter int MW = MODE_W,
  parameter int SW = STATE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shdn_n,
  input  logic [MW-1:0] mode,
  input  logic          run_pri,
  input  logic          run_sec,
  input  logic          lead_d,
  input  logic          trail_d,
  output logic          bias_en,
  output logic          en_lo,
  output logic          en_hi,
  output logic          pg_both,
  output logic [SW-1:0] op_state
);
  logic seq, hi_first, nxt_lo, nxt_hi;
  op_state_e nxt_state;

  always_comb begin
    seq      = mode_sequenced(mode);
    hi_first = mode_hi_leads(mode);
    if (!seq) begin
      nxt_lo = shdn_n & run_pri;
      nxt_hi = shdn_n & run_sec;
    end else if (hi_first) begin
      nxt_lo = shdn_n & trail_d;
      nxt_hi = shdn_n & lead_d;
    end else begin
      nxt_lo = shdn_n & lead_d;
      nxt_hi = shdn_n & trail_d;
    end
    if (!shdn_n)                nxt_state = ST_SHUTDOWN;
    else if (nxt_lo || nxt_hi)  nxt_state = ST_RUN;
    else                        nxt_state = ST_STANDBY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bias_en  <= 1'b0;
      en_lo    <= 1'b0;
      en_hi    <= 1'b0;
      pg_both  <= 1'b0;
      op_state <= SW'(ST_SHUTDOWN);
    end else begin
      bias_en  <= shdn_n;
      en_lo    <= nxt_lo;
      en_hi    <= nxt_hi;
      pg_both  <= seq;
      op_state <= SW'(nxt_state);
    end
  end
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int MW = MODE_W,
  parameter int SW = STATE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shdn_n,
  input  logic          run_pri,
  input  logic          run_sec,
  input  logic [MW-1:0] seq_mode,
  input  logic          cap_above,
  output logic          bias_en,
  output logic          en_lo,
  output logic          en_hi,
  output logic          pg_both,
  output logic [SW-1:0] op_state
);
  logic          pri_rise;
  logic [MW-1:0] mode_q;
  logic          mode_same, allow, lead_d, trail_d;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MW'(SEQ_INDEP);
    else     mode_q <= seq_mode;
  end

  assign mode_same = (mode_q == seq_mode);
  assign allow     = shdn_n & mode_sequenced(seq_mode);

  pwrseq_edge #(.INIT(1'b1)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .din  (run_pri),
    .rise (pri_rise)
  );

  pwrseq_chain u_chain (
    .clk        (clk),
    .rst        (rst),
    .allow      (allow),
    .start_rise (pri_rise),
    .hold       (run_pri),
    .mode_same  (mode_same),
    .cap_above  (cap_above),
    .lead_d     (lead_d),
    .trail_d    (trail_d)
  );

  pwrseq_outreg #(.MW(MW), .SW(SW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .shdn_n   (shdn_n),
    .mode     (seq_mode),
    .run_pri  (run_pri),
    .run_sec  (run_sec),
    .lead_d   (lead_d),
    .trail_d  (trail_d),
    .bias_en  (bias_en),
    .en_lo    (en_lo),
    .en_hi    (en_hi),
    .pg_both  (pg_both),
    .op_state (op_state)
  );
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk (
  input logic       clk,
  input logic       rst,
  input logic       shdn_n,
  input logic       run_pri,
  input logic       run_sec,
  input logic [1:0] seq_mode,
  input logic       cap_above,
  input logic       bias_en,
  input logic       en_lo,
  input logic       en_hi,
  input logic       pg_both,
  input logic [1:0] op_state
);
  assert_shutdown_off_R1: assert property (@(posedge clk) disable iff (rst)
    !shdn_n |=> (!en_lo && !en_hi && !bias_en && op_state == 2'b00));

  assert_indep_follow_R3: assert property (@(posedge clk) disable iff (rst)
    (seq_mode[1] && shdn_n) |=> (en_lo == $past(run_pri) && en_hi == $past(run_sec)));

  assert_seq_pri_low_R6: assert property (@(posedge clk) disable iff (rst)
    (!seq_mode[1] && !run_pri) |=> (!en_lo && !en_hi));

  assert_pg_both_R7: assert property (@(posedge clk) disable iff (rst)
    !seq_mode[1] |=> pg_both);

  assert_pg_lo_only_R7: assert property (@(posedge clk) disable iff (rst)
    seq_mode[1] |=> !pg_both);

  assert_run_state_R8: assert property (@(posedge clk) disable iff (rst)
    (en_lo || en_hi) |-> op_state == 2'b10);

  assert_trail_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (seq_mode == 2'b00 && en_lo && run_pri && shdn_n && $stable(seq_mode)) |=> en_lo);

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!en_lo && !en_hi && !bias_en && !pg_both));
endmodule

bind pwrseq_top pwrseq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .shdn_n    (shdn_n),
  .run_pri   (run_pri),
  .run_sec   (run_sec),
  .seq_mode  (seq_mode),
  .cap_above (cap_above),
  .bias_en   (bias_en),
  .en_lo     (en_lo),
  .en_hi     (en_hi),
  .pg_both   (pg_both),
  .op_state  (op_state)
);

// File: tb/pwrseq_top_tb.sv
module pwrseq_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       shdn_n = 1'b0, run_pri = 1'b0, run_sec = 1'b0, cap_above = 1'b0;
  logic [1:0] seq_mode = 2'b10;
  logic       bias_en, en_lo, en_hi, pg_both;
  logic [1:0] op_state;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwrseq_top u_dut (
    .clk(clk), .rst(rst), .shdn_n(shdn_n), .run_pri(run_pri), .run_sec(run_sec),
    .seq_mode(seq_mode), .cap_above(cap_above), .bias_en(bias_en), .en_lo(en_lo),
    .en_hi(en_hi), .pg_both(pg_both), .op_state(op_state)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // expected: {bias_en, en_lo, en_hi, pg_both, op_state}
  task automatic chk(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {bias_en, en_lo, en_hi, pg_both, op_state};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic t_reset_R10;
    rst = 1'b1; shdn_n = 1'b1; run_pri = 1'b1; run_sec = 1'b1; seq_mode = 2'b10;
    tick(2);
    chk("R10 reset", 6'b000000);
    rst = 1'b0; run_pri = 1'b0; run_sec = 1'b0; shdn_n = 1'b0;
    tick(1);
  endtask

  task automatic t_shutdown_R1_R2;
    shdn_n = 1'b0; run_pri = 1'b1; run_sec = 1'b1; seq_mode = 2'b10;
    tick(1);
    chk("R1 shutdown", 6'b000000);
    run_pri = 1'b0; run_sec = 1'b0; shdn_n = 1'b1;
    tick(1);
    chk("R2 standby", 6'b100001);
  endtask

  task automatic t_indep_R3;
    seq_mode = 2'b10; shdn_n = 1'b1;
    run_pri = 1'b1; run_sec = 1'b0; cap_above = 1'b1; tick(1);
    chk("R3 lo only", 6'b110010);
    run_pri = 1'b0; run_sec = 1'b1; cap_above = 1'b0; tick(1);
    chk("R3 hi only", 6'b101010);
    seq_mode = 2'b11; run_pri = 1'b1; tick(1);
    chk("R3 code11 both, R8 run", 6'b111010);
    run_pri = 1'b0; run_sec = 1'b0; cap_above = 1'b1; tick(1);
    chk("R3 cap ignored", 6'b100001);
    cap_above = 1'b0;
  endtask

  task automatic t_hi_leads_R4;
    seq_mode = 2'b00; shdn_n = 1'b1; run_pri = 1'b0; cap_above = 1'b0; run_sec = 1'b1;
    tick(2);
    chk("R7 pg both, R6 run_sec ignored", 6'b100101);
    run_pri = 1'b1; tick(1);
    chk("R4 high rail leads", 6'b101110);
    tick(2);
    chk("R4 wait for cap", 6'b101110);
    cap_above = 1'b1; tick(1);
    chk("R4 low rail trails", 6'b111110);
    cap_above = 1'b0; tick(3);
    chk("R9 cap drop ignored", 6'b111110);
    run_pri = 1'b0; tick(1);
    chk("R9 pri fall clears", 6'b100101);
    run_pri = 1'b1; cap_above = 1'b1; tick(1);
    chk("R4 cap early: lead only", 6'b101110);
    tick(1);
    chk("R4 cap early: trail next", 6'b111110);
    run_pri = 1'b0; cap_above = 1'b0; run_sec = 1'b0; tick(1);
  endtask

  task automatic t_lo_leads_R5;
    seq_mode = 2'b01; shdn_n = 1'b1; run_pri = 1'b0; cap_above = 1'b0;
    tick(2);
    run_pri = 1'b1; tick(1);
    chk("R5 low rail leads", 6'b110110);
    cap_above = 1'b1; tick(1);
    chk("R5 high rail trails", 6'b111110);
    shdn_n = 1'b0; tick(1);
    chk("R9 shutdown clears", 6'b000100);
    shdn_n = 1'b1; tick(2);
    chk("R9 no restart without edge", 6'b100101);
    run_pri = 1'b0; cap_above = 1'b0; tick(1);
  endtask

  task automatic t_held_high_R6;
    seq_mode = 2'b00; shdn_n = 1'b0; run_pri = 1'b1;
    tick(1);
    shdn_n = 1'b1; tick(2);
    chk("R6 held-high start ignored", 6'b100101);
    run_pri = 1'b0; tick(1);
    run_pri = 1'b1; tick(1);
    chk("R6 fresh edge starts", 6'b101110);
  endtask

  task automatic t_mode_swap_R11;
    cap_above = 1'b1; tick(1);
    chk("R11 setup both on", 6'b111110);
    seq_mode = 2'b01; tick(2);
    chk("R11 mode swap clears", 6'b100101);
    run_pri = 1'b0; cap_above = 1'b0; tick(1);
    run_pri = 1'b1; tick(1);
    chk("R11 restart in new mode", 6'b110110);
    seq_mode = 2'b10; run_pri = 1'b0; tick(1);
    chk("R7 indep pg low-only", 6'b100001);
  endtask

  initial begin
    t_reset_R10();
    t_shutdown_R1_R2();
    t_indep_R3();
    t_hi_leads_R4();
    t_lo_leads_R5();
    t_held_high_R6();
    t_mode_swap_R11();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule